// File: doc/BRIEF.md
# Extended-Precision Zero-Compare Flag Unit

This unit takes one 80-bit extended-precision floating-point value and reports how it relates to zero. It returns a four-bit condition code and three exception indications. Before the sign is looked at, the value is sorted into one of six classes: zero, denormal, normal, infinity, NaN or unsupported encoding. An empty source register takes precedence over the operand and is reported as a stack underflow.

A single-cycle start strobe launches a test. One clock later the results appear, registered, on the outputs, together with a one-cycle done pulse. The results then stay unchanged until the next strobe. Writing the results into a status word, masking exceptions and raising traps belong to the surrounding logic.

The operand layout is fixed because the classification depends on it:
- bit 79 is the sign;
- bits 78:64 hold the biased exponent;
- bits 63:0 hold the significand, and bit 63 is an explicit integer bit.

Top module: `fp_zero_cmp`

## Requirements
- R1: A normal positive operand (exponent neither 0 nor all ones, integer bit 1, sign 0) gives cond_o = 4'b0000 with all exception flags low, in the cycle after start_i.
- R2: A normal negative operand (same classes as R1 but sign 1) gives cond_o = 4'b0001 with all exception flags low.
- R3: An operand with exponent 0, integer bit 0 and fraction 0 gives cond_o = 4'b1000 and no flags, whatever the sign bit.
- R4: An operand with an all-ones exponent, integer bit 1 and a nonzero fraction in bits 62:0 (a NaN) gives the unordered code cond_o = 4'b1101 and raises inv_o.
- R5: An operand whose exponent is nonzero and whose integer bit is 0 is an unsupported encoding. It gives cond_o = 4'b1101 and raises inv_o.
- R6: An operand with exponent 0 and a nonzero significand raises dnrm_o. This includes the case where the integer bit is set. The code is 4'b0000 when the sign is 0 and 4'b0001 when the sign is 1, and inv_o stays low.
- R7: When empty_i is high at the strobe, the operand is ignored. The result is cond_o = 4'b1101 with undf_o and inv_o high and dnrm_o low.
- R8: cond_o[1] is 0 after every test.
- R9: done_o is high exactly in the cycle after each start_i and low otherwise. When no strobe arrives, all result outputs keep their values.
- R10: An infinity (all-ones exponent, integer bit 1, fraction 0) is an ordered value: cond_o = 4'b0000 for sign 0 and 4'b0001 for sign 1, with no flags.
- R11: While rst_n is low and in the first cycle after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to test the operand |
| empty_i | input | 1 | Source register holds no value |
| operand_i | input | 80 | Extended-precision value to test |
| done_o | output | 1 | Result valid pulse, one cycle after start_i |
| cond_o | output | 4 | Condition code: bit 3 equal/unordered, bit 2 unordered, bit 1 zero, bit 0 less/unordered |
| inv_o | output | 1 | Invalid operand (NaN, unsupported encoding or underflow) |
| undf_o | output | 1 | Stack underflow |
| dnrm_o | output | 1 | Denormal operand |

## Verification
All state sits in one register stage, so a wrong internal value shows at the ports in the cycle right after the strobe. A misclassified encoding appears there as a wrong code or a wrong flag. A done register that misses a strobe, or a result register that changes between strobes, shows one cycle later as a missing or extra pulse or as a changed code. Random operands are weighted toward the boundary classes: exponent zero, all-ones exponent, and integer bit clear.

// File: rtl/fzc_pkg.sv
package fzc_pkg;

    // Operand class after decoding the extended-precision fields
    typedef enum logic [2:0] {
        CLS_ZERO   = 3'd0,
        CLS_DENORM = 3'd1,
        CLS_NORMAL = 3'd2,
        CLS_INF    = 3'd3,
        CLS_NAN    = 3'd4,
        CLS_UNSUP  = 3'd5
    } opnd_cls_e;

    localparam int CC_W = 4;

    // Condition codes; bit 3 = equal/unordered, bit 2 = unordered, bit 1 = 0, bit 0 = less
    localparam logic [CC_W-1:0] CC_ABOVE = 4'b0000;
    localparam logic [CC_W-1:0] CC_BELOW = 4'b0001;
    localparam logic [CC_W-1:0] CC_EQUAL = 4'b1000;
    localparam logic [CC_W-1:0] CC_UNORD = 4'b1101;

    typedef struct packed {
        logic            done;
        logic [CC_W-1:0] cond;
        logic            inv;
        logic            undf;
        logic            dnrm;
    } fzc_state_t;

endpackage

// File: rtl/fzc_classify.sv
module fzc_classify
    import fzc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64
) (
    input  logic [EXP_W-1:0] exp_i,
    input  logic [SIG_W-1:0] sig_i,
    output opnd_cls_e        cls_o
);

    localparam int FRAC_W = SIG_W - 1;

    logic              int_bit;
    logic [FRAC_W-1:0] frac;
    logic              exp_zero;
    logic              exp_ones;
    logic              frac_zero;

    assign int_bit   = sig_i[SIG_W-1];
    assign frac      = sig_i[FRAC_W-1:0];
    assign exp_zero  = (exp_i == '0);
    assign exp_ones  = (exp_i == '1);
    assign frac_zero = (frac == '0);

    always_comb begin
        cls_o = CLS_NORMAL;
        if (exp_zero) begin
            // integer bit set with zero exponent counts as denormal
            if (!int_bit && frac_zero) cls_o = CLS_ZERO;
            else                       cls_o = CLS_DENORM;
        end else if (!int_bit) begin
            cls_o = CLS_UNSUP;
        end else if (exp_ones) begin
            cls_o = frac_zero ? CLS_INF : CLS_NAN;
        end else begin
            cls_o = CLS_NORMAL;
        end
    end

    always_comb begin
        if (!exp_zero && !int_bit)
            assert_unsup_class_R5: assert (cls_o == CLS_UNSUP);
    end

endmodule

// File: rtl/fzc_encode.sv
module fzc_encode
    import fzc_pkg::*;
(
    input  opnd_cls_e        cls_i,
    input  logic             sign_i,
    input  logic             empty_i,
    output logic [CC_W-1:0]  cond_o,
    output logic             inv_o,
    output logic             undf_o,
    output logic             dnrm_o
);

    logic [CC_W-1:0] signed_code;

    assign signed_code = sign_i ? CC_BELOW : CC_ABOVE;

    always_comb begin
        cond_o = CC_UNORD;
        inv_o  = 1'b0;
        undf_o = 1'b0;
        dnrm_o = 1'b0;
        if (empty_i) begin
            cond_o = CC_UNORD;
            inv_o  = 1'b1;
            undf_o = 1'b1;
        end else begin
            unique case (cls_i)
                CLS_ZERO:   cond_o = CC_EQUAL;
                CLS_DENORM: begin
                    cond_o = signed_code;
                    dnrm_o = 1'b1;
                end
                CLS_NORMAL,
                CLS_INF:    cond_o = signed_code;
                CLS_NAN,
                CLS_UNSUP:  begin
                    cond_o = CC_UNORD;
                    inv_o  = 1'b1;
                end
                default:    begin
                    cond_o = CC_UNORD;
                    inv_o  = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        if (dnrm_o) assert_dnrm_not_inv_R6: assert (!inv_o && !undf_o);
    end

endmodule

// File: rtl/fp_zero_cmp.sv
module fp_zero_cmp
    import fzc_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int SIG_W = 64,
    localparam int OP_W = 1 + EXP_W + SIG_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            empty_i,
    input  logic [OP_W-1:0] operand_i,
    output logic            done_o,
    output logic [CC_W-1:0] cond_o,
    output logic            inv_o,
    output logic            undf_o,
    output logic            dnrm_o
);

    localparam int SIGN_POS = OP_W - 1;

    logic             sign;
    logic [EXP_W-1:0] exp_f;
    logic [SIG_W-1:0] sig_f;
    opnd_cls_e        cls;
    logic [CC_W-1:0]  enc_cond;
    logic             enc_inv;
    logic             enc_undf;
    logic             enc_dnrm;

    fzc_state_t state_d;
    fzc_state_t state_q;

    assign sign  = operand_i[SIGN_POS];
    assign exp_f = operand_i[SIGN_POS-1 -: EXP_W];
    assign sig_f = operand_i[SIG_W-1:0];

    fzc_classify #(
        .EXP_W (EXP_W),
        .SIG_W (SIG_W)
    ) i_classify (
        .exp_i (exp_f),
        .sig_i (sig_f),
        .cls_o (cls)
    );

    fzc_encode i_encode (
        .cls_i   (cls),
        .sign_i  (sign),
        .empty_i (empty_i),
        .cond_o  (enc_cond),
        .inv_o   (enc_inv),
        .undf_o  (enc_undf),
        .dnrm_o  (enc_dnrm)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = start_i;
        if (start_i) begin
            state_d.cond = enc_cond;
            state_d.inv  = enc_inv;
            state_d.undf = enc_undf;
            state_d.dnrm = enc_dnrm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign done_o = state_q.done;
    assign cond_o = state_q.cond;
    assign inv_o  = state_q.inv;
    assign undf_o = state_q.undf;
    assign dnrm_o = state_q.dnrm;

    assert_done_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    assert_no_spurious_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(cond_o) && $stable(inv_o) && $stable(undf_o) && $stable(dnrm_o)));
    assert_underflow_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && empty_i) |=> (cond_o == CC_UNORD && inv_o && undf_o && !dnrm_o));
    assert_c1_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !cond_o[1]);
    assert_inv_unordered_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && inv_o) |-> (cond_o == CC_UNORD));

endmodule

// File: tb/test_fp_zero_cmp.sv
module test_fp_zero_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        empty_i = 1'b0;
    logic [79:0] operand_i = '0;
    logic        done_o;
    logic [3:0]  cond_o;
    logic        inv_o;
    logic        undf_o;
    logic        dnrm_o;

    int n_vec  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    fp_zero_cmp i_fp_zero_cmp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .empty_i   (empty_i),
        .operand_i (operand_i),
        .done_o    (done_o),
        .cond_o    (cond_o),
        .inv_o     (inv_o),
        .undf_o    (undf_o),
        .dnrm_o    (dnrm_o)
    );

    // Expected result packed as {cond[3:0], inv, undf, dnrm}
    function automatic logic [6:0] model(input logic [79:0] v, input logic emp);
        logic        s;
        logic [14:0] e;
        logic        j;
        logic [62:0] f;
        s = v[79]; e = v[78:64]; j = v[63]; f = v[62:0];
        if (emp)                          return {4'b1101, 3'b110};
        if (e != 0 && !j)                 return {4'b1101, 3'b100};
        if (e == 15'h7fff && f != 0)      return {4'b1101, 3'b100};
        if (e == 0 && !j && f == 0)       return {4'b1000, 3'b000};
        if (e == 0)                       return {3'b000, s, 3'b001};
        return {3'b000, s, 3'b000};
    endfunction

    function automatic string req_of(input logic [79:0] v, input logic emp);
        if (emp) return "R7";
        if (v[78:64] != 0 && !v[63]) return "R5";
        if (v[78:64] == 15'h7fff) return (v[62:0] != 0) ? "R4" : "R10";
        if (v[78:64] == 0) return (v[63:0] == 0) ? "R3" : "R6";
        return v[79] ? "R2" : "R1";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [79:0] v, input logic emp);
        logic [6:0] e;
        string r;
        e = model(v, emp);
        r = req_of(v, emp);
        @(negedge clk);
        operand_i = v; empty_i = emp; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        operand_i = {$urandom, $urandom, $urandom};
        empty_i = $urandom % 2;
        check("R9 done", {31'b0, done_o}, 32'd1);
        check(r, {25'b0, cond_o, inv_o, undf_o, dnrm_o}, {25'b0, e});
        check("R8", {31'b0, cond_o[1]}, 32'd0);
        @(negedge clk);
        check("R9 idle", {31'b0, done_o}, 32'd0);
        check("R9 hold", {25'b0, cond_o, inv_o, undf_o, dnrm_o}, {25'b0, e});
    endtask

    function automatic logic [79:0] make_op(input int k);
        logic [79:0] v;
        v = {$urandom, $urandom, $urandom};
        case (k)
            0: begin v[78:64] = 15'd0; v[63:0] = '0; end
            1: begin v[78:64] = 15'd0; if (v[63:0] == 0) v[0] = 1'b1; end
            2: begin v[78:64] = 15'h7fff; v[63] = 1'b1; v[62:0] = '0; end
            3: begin v[78:64] = 15'h7fff; v[63] = 1'b1; if (v[62:0] == 0) v[5] = 1'b1; end
            4: begin if (v[78:64] == 0) v[64] = 1'b1; v[63] = 1'b0; end
            default: begin
                if (v[78:64] == 0) v[70] = 1'b1;
                if (v[78:64] == 15'h7fff) v[66] = 1'b0;
                v[63] = 1'b1;
            end
        endcase
        return v;
    endfunction

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        #3;
        // R11: reset state
        check("R11 reset", {25'b0, done_o, cond_o, inv_o, undf_o}, 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after", {24'b0, done_o, cond_o, inv_o, undf_o, dnrm_o}, 32'd0);

        // directed corners
        run_one({1'b0, 15'h3fff, 1'b1, 63'd0}, 1'b0);              // R1 +1.0
        run_one({1'b1, 15'h3fff, 1'b1, 63'd0}, 1'b0);              // R2 -1.0
        run_one({1'b0, 15'd0, 64'd0}, 1'b0);                       // R3 +0
        run_one({1'b1, 15'd0, 64'd0}, 1'b0);                       // R3 -0
        run_one({1'b0, 15'h7fff, 1'b1, 63'd1}, 1'b0);              // R4 NaN
        run_one({1'b1, 15'h7fff, 1'b1, 1'b1, 62'd0}, 1'b0);        // R4 quiet NaN
        run_one({1'b0, 15'h7fff, 1'b0, 63'd0}, 1'b0);              // R5 pseudo-inf
        run_one({1'b1, 15'h0001, 1'b0, 63'd7}, 1'b0);              // R5 unnormal
        run_one({1'b1, 15'd0, 1'b0, 63'd1}, 1'b0);                 // R6 denormal neg
        run_one({1'b0, 15'd0, 1'b1, 63'd0}, 1'b0);                 // R6 pseudo-denormal
        run_one({1'b1, 15'h7fff, 1'b1, 63'd0}, 1'b0);              // R10 -inf
        run_one({1'b0, 15'h7fff, 1'b1, 63'd0}, 1'b0);              // R10 +inf
        run_one({1'b0, 15'h3fff, 1'b1, 63'd0}, 1'b1);              // R7 empty
        run_one({1'b0, 15'd0, 1'b1, 63'd0}, 1'b1);                 // R7 empty over denormal

        for (int i = 0; i < 400; i++) begin
            run_one(make_op($urandom % 7), ($urandom % 10) == 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule